// File: doc/BRIEF.md
# CSR Access and Privilege Checker

This block carries out one control-and-status-register instruction per cycle against a small local register store. Each request brings a 12-bit register address, an operation (read only, swap, bit set or bit clear), an operand and the privilege level of the requesting code. In the same cycle the block returns the register's visible old value. It then either commits a masked update at the next clock edge or raises a fault with a two-bit cause.

The store holds one status word, one interrupt-enable word, one interrupt-pending word, a translation-control word, an 8-bit floating-point control byte and a free-running cycle counter. The status, enable and pending words each appear at three addresses, one per privilege level. Each of these addresses shows only the bits in its own visibility mask, so a write through a narrow view leaves the hidden bits alone. The floating-point byte appears whole at one address and as its flag field and rounding field at two others.

Every request gets a verdict from a fixed priority chain: idle, read, commit or fault. The verdict drives the outputs and the write enable of the store.

Top module: `csr_access_unit`

## Requirements
- R1: With `req_valid` low, `rd_data`, `commit` and `fault` are all zero. With `req_valid` high, `rd_data` shows the old value ANDed with the address's visibility mask in the same cycle, whether the request commits or faults.
- R2: An address outside the map faults with cause 2'b00, shows zero on `rd_data` and changes no state. The map is: 0x000 user status, 0x001 flags, 0x002 rounding mode, 0x003 whole float byte, 0x004 user enable, 0x044 user pending, 0x100 supervisor status, 0x104 supervisor enable, 0x144 supervisor pending, 0x180 translation, 0x300 machine status, 0x304 machine enable, 0x344 machine pending, 0xC00 cycle counter.
- R3: Any access to 0x300 from a privilege other than machine (`req_priv` 2'b11) faults with cause 2'b01.
- R4: An access to 0x180 faults with cause 2'b01 when `req_priv` is neither supervisor (2'b01) nor machine. It also faults with that cause in supervisor mode while bit `TVM_BIT` of the status word is 1. Machine mode is never refused.
- R5: `req_op` 2'b00 reads only. 2'b01 replaces the value with the operand. 2'b10 ORs the operand into the old visible value. 2'b11 ANDs the old visible value with the operand's complement. The result is ANDed with the visibility mask.
- R6: A committed write stores (old full value AND NOT mask) OR new visible value, so bits outside the view keep their values.
- R7: When the new visible value differs from the old one and address bits 11:10 are 2'b11, the request faults with cause 2'b10 and nothing is written. A set or clear with a zero operand at such an address does not fault.
- R8: On the nine status, enable and pending addresses, a write attempt that leaves the full value unchanged faults with cause 2'b11. A write attempt is a swap, or a set or clear with a nonzero operand. At other addresses an unchanged value neither commits nor faults.
- R9: 0x003 reads the flags in bits 4:0 and the rounding mode in bits 7:5, and a write splits the value back into those fields. 0x001 and 0x002 show each field alone in the low bits.
- R10: The counter at 0xC00 is zero at reset and adds one on every clock edge after reset is released.
- R11: `commit` is high exactly when a write takes place, never together with `fault`, and the new value is readable from the next cycle.
- R12: After reset the status word holds `STATUS_RST` and every other register holds zero.
- R13: When several faults apply to one request, the cause is chosen in this order: invalid address, then privilege, then read-only, then no-change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | 12 | Register address |
| req_op | input | 2 | 00 read, 01 swap, 10 set bits, 11 clear bits |
| req_operand | input | XLEN | Source operand |
| req_priv | input | 2 | 00 user, 01 supervisor, 11 machine (10 treated as user) |
| rd_data | output | XLEN | Visible old value |
| commit | output | 1 | The write takes effect at the coming edge |
| fault | output | 1 | Illegal-instruction fault |
| fault_cause | output | 2 | 00 address, 01 privilege, 10 read-only, 11 no-change |

## Verification
Privilege gating and the no-change test can apply to the same request. A supervisor-mode swap of the machine status word with its current value is one example. The bench sends such a request and expects cause 01. A set to the cycle counter at 0xC01, which is both unmapped and in the read-only space, must report cause 00. The exhaustive sweep crosses every mapped address, two unmapped ones, all four privilege codes, all operations, several operands and both settings of the translation trap bit. Each outcome is compared with a bench model, so every overlap of the four fault causes comes up many times.

// File: rtl/csr_access_pkg.sv
package csr_access_pkg;

    localparam int FLAG_W = 5;
    localparam int RMODE_W = 3;
    localparam int FPB_W = FLAG_W + RMODE_W;

    localparam logic [11:0] A_USTATUS = 12'h000;
    localparam logic [11:0] A_FLAGS   = 12'h001;
    localparam logic [11:0] A_RMODE   = 12'h002;
    localparam logic [11:0] A_FPBYTE  = 12'h003;
    localparam logic [11:0] A_UIE     = 12'h004;
    localparam logic [11:0] A_UIP     = 12'h044;
    localparam logic [11:0] A_SSTATUS = 12'h100;
    localparam logic [11:0] A_SIE     = 12'h104;
    localparam logic [11:0] A_SIP     = 12'h144;
    localparam logic [11:0] A_XLATE   = 12'h180;
    localparam logic [11:0] A_MSTATUS = 12'h300;
    localparam logic [11:0] A_MIE     = 12'h304;
    localparam logic [11:0] A_MIP     = 12'h344;
    localparam logic [11:0] A_CYCLE   = 12'hC00;

    typedef enum logic [3:0] {
        VW_NONE, VW_STATUS, VW_IE, VW_IP, VW_XLATE,
        VW_FLAGS, VW_RMODE, VW_FPBYTE, VW_CYCLE
    } view_e;

    typedef enum logic [1:0] {
        OP_READ = 2'b00, OP_SWAP = 2'b01, OP_SET = 2'b10, OP_CLEAR = 2'b11
    } csr_op_e;

    typedef enum logic [1:0] {
        PRIV_USER = 2'b00, PRIV_SUPER = 2'b01, PRIV_RSVD = 2'b10, PRIV_MACHINE = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        CAUSE_BAD_ADDR = 2'b00, CAUSE_PRIV = 2'b01,
        CAUSE_READ_ONLY = 2'b10, CAUSE_NO_CHANGE = 2'b11
    } cause_e;

    typedef enum logic [1:0] {
        VD_IDLE, VD_READ, VD_COMMIT, VD_FAULT
    } verdict_e;

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
    import csr_access_pkg::*;
#(
    parameter int XLEN = 32,
    parameter logic [XLEN-1:0] STATUS_M_MASK = 32'h0010_19AA,
    parameter logic [XLEN-1:0] STATUS_S_MASK = 32'h0000_0122,
    parameter logic [XLEN-1:0] STATUS_U_MASK = 32'h0000_0011,
    parameter logic [XLEN-1:0] INT_M_MASK = 32'h0000_0AAA,
    parameter logic [XLEN-1:0] INT_S_MASK = 32'h0000_0222,
    parameter logic [XLEN-1:0] INT_U_MASK = 32'h0000_0111,
    parameter logic [XLEN-1:0] XLATE_MASK = 32'hFFFF_FFFF
) (
    input  logic [11:0]     addr,
    output view_e           view,
    output logic            hit,
    output logic [XLEN-1:0] mask,
    output logic            special,
    output logic            machine_only,
    output logic            xlate
);
    localparam logic [XLEN-1:0] FLAGS_MASK = XLEN'({FLAG_W{1'b1}});
    localparam logic [XLEN-1:0] RMODE_MASK = XLEN'({RMODE_W{1'b1}});
    localparam logic [XLEN-1:0] FPB_MASK   = XLEN'({FPB_W{1'b1}});
    localparam logic [XLEN-1:0] ALL_MASK   = {XLEN{1'b1}};

    always_comb begin
        view = VW_NONE;
        hit = 1'b1;
        mask = '0;
        special = 1'b0;
        machine_only = 1'b0;
        xlate = 1'b0;
        unique case (addr)
            A_MSTATUS: begin view = VW_STATUS; mask = STATUS_M_MASK; special = 1'b1; machine_only = 1'b1; end
            A_SSTATUS: begin view = VW_STATUS; mask = STATUS_S_MASK; special = 1'b1; end
            A_USTATUS: begin view = VW_STATUS; mask = STATUS_U_MASK; special = 1'b1; end
            A_MIE:     begin view = VW_IE; mask = INT_M_MASK; special = 1'b1; end
            A_SIE:     begin view = VW_IE; mask = INT_S_MASK; special = 1'b1; end
            A_UIE:     begin view = VW_IE; mask = INT_U_MASK; special = 1'b1; end
            A_MIP:     begin view = VW_IP; mask = INT_M_MASK; special = 1'b1; end
            A_SIP:     begin view = VW_IP; mask = INT_S_MASK; special = 1'b1; end
            A_UIP:     begin view = VW_IP; mask = INT_U_MASK; special = 1'b1; end
            A_XLATE:   begin view = VW_XLATE; mask = XLATE_MASK; xlate = 1'b1; end
            A_FLAGS:   begin view = VW_FLAGS; mask = FLAGS_MASK; end
            A_RMODE:   begin view = VW_RMODE; mask = RMODE_MASK; end
            A_FPBYTE:  begin view = VW_FPBYTE; mask = FPB_MASK; end
            A_CYCLE:   begin view = VW_CYCLE; mask = ALL_MASK; end
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/csr_reg_store.sv
module csr_reg_store
    import csr_access_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int TVM_BIT = 20,
    parameter logic [XLEN-1:0] STATUS_RST = 32'h0000_1800
) (
    input  logic            clk,
    input  logic            rst_n,
    input  view_e           view,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_value,
    output logic [XLEN-1:0] rd_full,
    output logic            tvm
);
    logic [XLEN-1:0]  status_q, ie_q, ip_q, xlate_q, cycle_q;
    logic [FPB_W-1:0] fpb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= STATUS_RST;
            ie_q     <= '0;
            ip_q     <= '0;
            xlate_q  <= '0;
            fpb_q    <= '0;
            cycle_q  <= '0;
        end else begin
            cycle_q <= cycle_q + 1'b1;
            if (wr_en) begin
                unique case (view)
                    VW_STATUS: status_q <= wr_value;
                    VW_IE:     ie_q <= wr_value;
                    VW_IP:     ip_q <= wr_value;
                    VW_XLATE:  xlate_q <= wr_value;
                    VW_FLAGS:  fpb_q[FLAG_W-1:0] <= wr_value[FLAG_W-1:0];
                    VW_RMODE:  fpb_q[FPB_W-1:FLAG_W] <= wr_value[RMODE_W-1:0];
                    VW_FPBYTE: fpb_q <= wr_value[FPB_W-1:0];
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (view)
            VW_STATUS: rd_full = status_q;
            VW_IE:     rd_full = ie_q;
            VW_IP:     rd_full = ip_q;
            VW_XLATE:  rd_full = xlate_q;
            VW_FLAGS:  rd_full = XLEN'(fpb_q[FLAG_W-1:0]);
            VW_RMODE:  rd_full = XLEN'(fpb_q[FPB_W-1:FLAG_W]);
            VW_FPBYTE: rd_full = XLEN'(fpb_q);
            VW_CYCLE:  rd_full = cycle_q;
            default:   rd_full = '0;
        endcase
    end

    assign tvm = status_q[TVM_BIT];
endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
    import csr_access_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int TVM_BIT = 20,
    parameter logic [XLEN-1:0] STATUS_RST = 32'h0000_1800,
    parameter logic [XLEN-1:0] STATUS_M_MASK = 32'h0010_19AA,
    parameter logic [XLEN-1:0] STATUS_S_MASK = 32'h0000_0122,
    parameter logic [XLEN-1:0] STATUS_U_MASK = 32'h0000_0011,
    parameter logic [XLEN-1:0] INT_M_MASK = 32'h0000_0AAA,
    parameter logic [XLEN-1:0] INT_S_MASK = 32'h0000_0222,
    parameter logic [XLEN-1:0] INT_U_MASK = 32'h0000_0111,
    parameter logic [XLEN-1:0] XLATE_MASK = 32'hFFFF_FFFF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [11:0]     req_addr,
    input  logic [1:0]      req_op,
    input  logic [XLEN-1:0] req_operand,
    input  logic [1:0]      req_priv,
    output logic [XLEN-1:0] rd_data,
    output logic            commit,
    output logic            fault,
    output logic [1:0]      fault_cause
);
    view_e           view;
    logic            hit, special, machine_only, xlate, tvm;
    logic [XLEN-1:0] mask, old_full, old_vis, new_raw, new_vis, merged;
    logic            write_try, changed, ro_space, priv_bad;
    verdict_e        verdict;
    cause_e          cause;

    csr_addr_decode #(
        .XLEN(XLEN), .STATUS_M_MASK(STATUS_M_MASK), .STATUS_S_MASK(STATUS_S_MASK),
        .STATUS_U_MASK(STATUS_U_MASK), .INT_M_MASK(INT_M_MASK), .INT_S_MASK(INT_S_MASK),
        .INT_U_MASK(INT_U_MASK), .XLATE_MASK(XLATE_MASK)
    ) u_decode (
        .addr(req_addr), .view(view), .hit(hit), .mask(mask), .special(special),
        .machine_only(machine_only), .xlate(xlate)
    );

    csr_reg_store #(.XLEN(XLEN), .TVM_BIT(TVM_BIT), .STATUS_RST(STATUS_RST)) u_store (
        .clk(clk), .rst_n(rst_n), .view(view), .wr_en(verdict == VD_COMMIT),
        .wr_value(merged), .rd_full(old_full), .tvm(tvm)
    );

    // Operation on the visible value
    always_comb begin
        old_vis = old_full & mask;
        unique case (csr_op_e'(req_op))
            OP_READ:  new_raw = old_vis;
            OP_SWAP:  new_raw = req_operand;
            OP_SET:   new_raw = old_vis | req_operand;
            OP_CLEAR: new_raw = old_vis & ~req_operand;
            default:  new_raw = old_vis;
        endcase
        new_vis   = new_raw & mask;
        merged    = (old_full & ~mask) | new_vis;
        changed   = (new_vis != old_vis);
        write_try = (req_op == OP_SWAP) || ((req_op != OP_READ) && (req_operand != '0));
        ro_space  = (req_addr[11:10] == 2'b11);
        priv_bad  = (machine_only && req_priv != PRIV_MACHINE)
                  || (xlate && req_priv != PRIV_MACHINE && (req_priv != PRIV_SUPER || tvm));
    end

    // Verdict chain, fixed fault priority
    always_comb begin
        verdict = VD_IDLE;
        cause   = CAUSE_BAD_ADDR;
        if (req_valid) begin
            if (!hit) begin
                verdict = VD_FAULT; cause = CAUSE_BAD_ADDR;
            end else if (priv_bad) begin
                verdict = VD_FAULT; cause = CAUSE_PRIV;
            end else if (changed && ro_space) begin
                verdict = VD_FAULT; cause = CAUSE_READ_ONLY;
            end else if (special && write_try && merged == old_full) begin
                verdict = VD_FAULT; cause = CAUSE_NO_CHANGE;
            end else if (changed) begin
                verdict = VD_COMMIT;
            end else begin
                verdict = VD_READ;
            end
        end
    end

    // Outputs per verdict
    always_comb begin
        rd_data = '0;
        commit = 1'b0;
        fault = 1'b0;
        fault_cause = CAUSE_BAD_ADDR;
        unique case (verdict)
            VD_IDLE:   ;
            VD_READ:   rd_data = old_vis;
            VD_COMMIT: begin rd_data = old_vis; commit = 1'b1; end
            VD_FAULT:  begin rd_data = old_vis; fault = 1'b1; fault_cause = cause; end
            default:   ;
        endcase
    end
endmodule

// File: rtl/csr_access_unit_checker.sv
module csr_access_unit_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [11:0]     req_addr,
    input logic [1:0]      req_op,
    input logic [XLEN-1:0] req_operand,
    input logic [1:0]      req_priv,
    input logic [XLEN-1:0] rd_data,
    input logic            commit,
    input logic            fault,
    input logic [1:0]      fault_cause
);
    logic special_addr;
    assign special_addr = (req_addr == 12'h000) || (req_addr == 12'h004) || (req_addr == 12'h044)
                       || (req_addr == 12'h100) || (req_addr == 12'h104) || (req_addr == 12'h144)
                       || (req_addr == 12'h300) || (req_addr == 12'h304) || (req_addr == 12'h344);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!fault && !commit && rd_data == '0));

    assert_bad_addr_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && fault_cause == 2'b00) |-> rd_data == '0);

    assert_priv_scope_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && fault_cause == 2'b01) |-> (req_addr == 12'h300 || req_addr == 12'h180));

    assert_machine_xlate_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr == 12'h180 && req_priv == 2'b11) |-> !fault);

    assert_read_op_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b00) |-> !commit);

    assert_ro_cause_space_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && fault_cause == 2'b10) |-> req_addr[11:10] == 2'b11);

    assert_no_ro_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> req_addr[11:10] != 2'b11);

    assert_nochange_special_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && fault_cause == 2'b11) |-> (special_addr && (req_op == 2'b01 || req_operand != '0)));

    assert_commit_excl_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !fault);
endmodule

bind csr_access_unit csr_access_unit_checker #(.XLEN(XLEN)) u_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_op(req_op), .req_operand(req_operand), .req_priv(req_priv),
    .rd_data(rd_data), .commit(commit), .fault(fault), .fault_cause(fault_cause)
);

// File: tb/csr_access_unit_test.sv
module csr_access_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] ST_RST = 32'h0000_1800;
    localparam logic [31:0] SM_M = 32'h0010_19AA, SM_S = 32'h0000_0122, SM_U = 32'h0000_0011;
    localparam logic [31:0] IM_M = 32'h0000_0AAA, IM_S = 32'h0000_0222, IM_U = 32'h0000_0111;
    localparam logic [31:0] XL_M = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_op = '0;
    logic [31:0] req_operand = '0;
    logic [1:0]  req_priv = '0;
    logic [31:0] rd_data;
    logic        commit, fault;
    logic [1:0]  fault_cause;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [31:0] m_status, m_ie, m_ip, m_xl, m_cyc;
    logic [7:0]  m_fp;

    always #(CLK_PERIOD/2) clk = ~clk;

    csr_access_unit #(
        .XLEN(32), .TVM_BIT(20), .STATUS_RST(ST_RST),
        .STATUS_M_MASK(SM_M), .STATUS_S_MASK(SM_S), .STATUS_U_MASK(SM_U),
        .INT_M_MASK(IM_M), .INT_S_MASK(IM_S), .INT_U_MASK(IM_U), .XLATE_MASK(XL_M)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_op(req_op), .req_operand(req_operand), .req_priv(req_priv),
        .rd_data(rd_data), .commit(commit), .fault(fault), .fault_cause(fault_cause)
    );

    // R10: cycle counter model, counts edges after reset release
    always @(posedge clk or negedge rst_n)
        if (!rst_n) m_cyc <= '0;
        else m_cyc <= m_cyc + 1;

    function automatic logic [11:0] addr_of(int i);
        case (i)
            0: return 12'h000;  1: return 12'h001;  2: return 12'h002;  3: return 12'h003;
            4: return 12'h004;  5: return 12'h044;  6: return 12'h100;  7: return 12'h104;
            8: return 12'h144;  9: return 12'h180; 10: return 12'h300; 11: return 12'h304;
            12: return 12'h344; 13: return 12'hC00; 14: return 12'h301; default: return 12'hC01;
        endcase
    endfunction

    function automatic logic [31:0] operand_of(int k);
        case (k)
            0: return 32'h0;
            1: return 32'hFFFF_FFFF;
            2: return 32'h0000_0AAA;
            3: return 32'h0010_1122;
            default: return 32'hA5A5_5A5F;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] ard, input logic [31:0] erd,
                         input logic ac, input logic ec, input logic af, input logic ef,
                         input logic [1:0] aca, input logic [1:0] eca);
        n_cmp++;
        if (ard !== erd || ac !== ec || af !== ef || aca !== eca) begin
            n_bad++;
            $display("FAIL %s addr=%h: rd/commit/fault/cause actual %h/%b/%b/%b expected %h/%b/%b/%b",
                     tag, req_addr, ard, ac, af, aca, erd, ec, ef, eca);
        end
    endtask

    // One request per cycle: drive at the falling edge, compare, update model
    task automatic do_req(input logic [11:0] a, input logic [1:0] op, input logic [31:0] opd,
                          input logic [1:0] pv);
        logic hit, spec, mon, xl;
        logic [31:0] msk, full, ov, nv, nm, mg, erd;
        logic ec, ef, wtry;
        logic [1:0] eca;
        string tag;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_op = op; req_operand = opd; req_priv = pv;
        #1;
        hit = 1'b1; spec = 1'b0; mon = 1'b0; xl = 1'b0; msk = '0; full = '0;
        case (a)
            12'h300: begin msk = SM_M; full = m_status; spec = 1'b1; mon = 1'b1; end
            12'h100: begin msk = SM_S; full = m_status; spec = 1'b1; end
            12'h000: begin msk = SM_U; full = m_status; spec = 1'b1; end
            12'h304: begin msk = IM_M; full = m_ie; spec = 1'b1; end
            12'h104: begin msk = IM_S; full = m_ie; spec = 1'b1; end
            12'h004: begin msk = IM_U; full = m_ie; spec = 1'b1; end
            12'h344: begin msk = IM_M; full = m_ip; spec = 1'b1; end
            12'h144: begin msk = IM_S; full = m_ip; spec = 1'b1; end
            12'h044: begin msk = IM_U; full = m_ip; spec = 1'b1; end
            12'h180: begin msk = XL_M; full = m_xl; xl = 1'b1; end
            12'h001: begin msk = 32'h1F; full = {27'b0, m_fp[4:0]}; end
            12'h002: begin msk = 32'h07; full = {29'b0, m_fp[7:5]}; end
            12'h003: begin msk = 32'hFF; full = {24'b0, m_fp}; end
            12'hC00: begin msk = 32'hFFFF_FFFF; full = m_cyc; end
            default: hit = 1'b0;
        endcase
        ov = full & msk;
        case (op)
            2'b01: nv = opd;
            2'b10: nv = ov | opd;
            2'b11: nv = ov & ~opd;
            default: nv = ov;
        endcase
        nm = nv & msk;
        mg = (full & ~msk) | nm;
        wtry = (op == 2'b01) || (op != 2'b00 && opd != 0);
        erd = ov; ec = 1'b0; ef = 1'b1; eca = 2'b00;
        // R13: priority address > privilege > read-only > no-change
        if (!hit) begin eca = 2'b00; tag = "R2"; end
        else if ((mon && pv != 2'b11) || (xl && pv != 2'b11 && (pv != 2'b01 || m_status[20])))
            begin eca = 2'b01; tag = mon ? "R3" : "R4"; end
        else if (nm != ov && a[11:10] == 2'b11) begin eca = 2'b10; tag = "R7"; end
        else if (spec && wtry && mg == full) begin eca = 2'b11; tag = "R8"; end
        else begin
            ef = 1'b0;
            ec = (nm != ov);
            if (a == 12'h001 || a == 12'h002 || a == 12'h003) tag = "R9";
            else if (a == 12'hC00) tag = "R10";
            else if (ec && msk != 32'hFFFF_FFFF) tag = "R6";
            else tag = "R5";
        end
        check(tag, rd_data, erd, commit, ec, fault, ef, fault_cause, eca);
        if (ec) begin
            case (a)
                12'h300, 12'h100, 12'h000: m_status = mg;
                12'h304, 12'h104, 12'h004: m_ie = mg;
                12'h344, 12'h144, 12'h044: m_ip = mg;
                12'h180: m_xl = mg;
                12'h001: m_fp[4:0] = mg[4:0];
                12'h002: m_fp[7:5] = mg[2:0];
                12'h003: m_fp = mg[7:0];
                default: ;
            endcase
        end
    endtask

    task automatic idle_check;
        @(negedge clk);
        req_valid = 1'b0; req_addr = 12'h300; req_op = 2'b01; req_operand = 32'hFFFF_FFFF;
        req_priv = 2'b11;
        #1;
        check("R1", rd_data, 32'h0, commit, 1'b0, fault, 1'b0, fault_cause, 2'b00);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] c0, c1;
        m_status = ST_RST; m_ie = '0; m_ip = '0; m_xl = '0; m_fp = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset values
        do_req(12'h300, 2'b00, 32'h0, 2'b11);
        do_req(12'h304, 2'b00, 32'h0, 2'b11);
        do_req(12'h003, 2'b00, 32'h0, 2'b00);
        // R1: idle request
        idle_check();

        // R6: narrow view write keeps hidden bits, read back wide
        do_req(12'h300, 2'b01, 32'hFFFF_FFFF, 2'b11);
        do_req(12'h100, 2'b01, 32'h0, 2'b01);
        do_req(12'h300, 2'b00, 32'h0, 2'b11);

        // R13: privilege beats no-change; address beats read-only
        do_req(12'h300, 2'b01, m_status & SM_M, 2'b01);
        do_req(12'hC01, 2'b10, 32'h1, 2'b11);

        // R9: field split and recomposition
        do_req(12'h003, 2'b01, 32'h0000_00B5, 2'b00);
        do_req(12'h001, 2'b00, 32'h0, 2'b00);
        do_req(12'h002, 2'b00, 32'h0, 2'b00);
        do_req(12'h002, 2'b01, 32'h2, 2'b00);
        do_req(12'h003, 2'b00, 32'h0, 2'b00);

        // R10: counter rises by the number of edges between two reads
        do_req(12'hC00, 2'b00, 32'h0, 2'b00);
        c0 = rd_data;
        do_req(12'hC00, 2'b10, 32'h0, 2'b00);
        do_req(12'hC00, 2'b11, 32'h0, 2'b00);
        c1 = rd_data;
        check("R10", c1 - c0, 32'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);

        // Exhaustive sweep (R2 R3 R4 R5 R7 R8 R11 via model)
        for (int t = 0; t < 2; t++) begin
            do_req(12'h300, t ? 2'b10 : 2'b11, 32'h0010_0000, 2'b11);
            for (int i = 0; i < 16; i++)
                for (int p = 0; p < 4; p++)
                    for (int o = 0; o < 4; o++)
                        for (int k = 0; k < 5; k++)
                            do_req(addr_of(i), o[1:0], operand_of(k), p[1:0]);
        end

        // Final readback of every address in machine mode
        for (int i = 0; i < 16; i++) do_req(addr_of(i), 2'b00, 32'h0, 2'b11);
        idle_check();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule